// File: doc/BRIEF.md
# Receive Packet Queue with Control Words

This block buffers received packets between a network deserializer and a host. Words arrive on the write side one per cycle; an end-of-packet strobe then carries the error flags for that packet. Each packet is stored behind a 16-bit control word that holds its stored length and status. The block fills in that control word only when the packet ends, so the host never sees a packet that is still arriving.

The host drains the queue through one 16-bit read port. It watches a queue-empty flag or a receive interrupt, reads the control word, then reads as many words as the count says. The port is look-ahead: the value on `rd_data` is the word the next read returns, and a read pulse advances it. When nothing is queued, the port holds an empty-marker control word, and reads do not advance anything. An `init` input empties the queue at once.

Top module: `rx_pkt_queue`

## Requirements
- R1: A control word carries the stored word count in bits 11:0, the CRC-error flag in bit 12, the collision flag in bit 13, the overflow flag in bit 14, and 0 in bit 15.
- R2: Words of a packet that has not yet ended leave `q_empty` and `rd_data` unchanged.
- R3: `q_empty` is 1 exactly when neither the port nor the buffer holds an unread word of a completed packet.
- R4: While the queue is empty, `rd_data` is the empty marker 0x8000, and read pulses return that same value without consuming anything.
- R5: `rx_irq` is high exactly when `q_empty` is low.
- R6: After the queue goes from empty to non-empty, the first read returns 0x8000 and the next returns the control word. A packet already queued behind the one being read follows its last data word with no extra word between them.
- R7: A packet that does not fit is truncated. Its control word has bit 14 set and a count equal to the data words actually stored.
- R8: An `init` pulse discards all stored words. In the next cycle `q_empty` is 1 and `rd_data` is 0x8000.
- R9: The buffer holds at most DEPTH words, control words included (default 2048). A word is stored only if its own slot and the control word slot both fit. A control word is still written at end of packet if its one slot fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous queue flush |
| wr_valid | input | 1 | Data word present on `wr_data` |
| wr_data | input | 16 | Received data word |
| eop_valid | input | 1 | End of the current packet |
| eop_crc_err | input | 1 | Packet failed its CRC check (with `eop_valid`) |
| eop_coll | input | 1 | Packet saw a collision or abort (with `eop_valid`) |
| rd_en | input | 1 | Host read pulse; consumes `rd_data` |
| rd_data | output | 16 | Look-ahead read port |
| q_empty | output | 1 | No completed packet word left to read |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that `wr_valid` and `eop_valid` are never high in the same cycle, because a control word and a data word would compete for the single write port. The bench always gives the end-of-packet strobe a cycle of its own. The properties also assume that `init` cancels any check still in progress, so every stimulus cycle that pulses `init` is excluded from them. Reads are freely mixed with writes, including a read in the same cycle a packet commits. Together they cover the case where the port reloads from an empty buffer just as a control word lands.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 12;
  localparam logic [WORD_W-1:0] EMPTY_MARK = 16'h8000;

  // control word: {0, overflow, collision, crc error, count}
  function automatic logic [WORD_W-1:0] ctrl_word(input logic [CNT_W-1:0] cnt,
                                                  input logic crc, input logic coll,
                                                  input logic ovf);
    return {1'b0, ovf, coll, crc, cnt};
  endfunction

  function automatic logic has_room(input int unsigned need, input int unsigned space);
    return need <= space;
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_writer.sv
`timescale 1ns/1ps
module rxq_writer import rxq_pkg::*; #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              eop_valid,
  input  logic              eop_crc_err,
  input  logic              eop_coll,
  input  logic [AW:0]       rd_ptr,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [AW:0]       commit_ptr
);
  logic [AW:0]      commit_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [AW:0]      used_w;
  int unsigned      space_w;
  logic             data_we, hdr_we;
  logic [AW:0]      data_ptr, next_commit;

  assign used_w      = commit_q - rd_ptr;
  assign space_w     = 32'(DEPTH) - 32'(used_w);
  assign data_we     = !init && wr_valid && has_room(32'(cnt_q) + 32'd2, space_w);
  assign hdr_we      = !init && eop_valid && has_room(32'(cnt_q) + 32'd1, space_w);
  assign data_ptr    = commit_q + (AW+1)'(cnt_q) + (AW+1)'(1);
  assign next_commit = data_ptr;

  assign mem_we     = data_we || hdr_we;
  assign mem_addr   = hdr_we ? commit_q[AW-1:0] : data_ptr[AW-1:0];
  assign mem_wdata  = hdr_we ? ctrl_word(cnt_q, eop_crc_err, eop_coll, ovf_q) : wr_data;
  assign commit_ptr = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (init) begin
      commit_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (eop_valid) begin
      if (hdr_we) commit_q <= next_commit;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_valid) begin
      if (data_we) cnt_q <= cnt_q + 1'b1;
      else         ovf_q <= 1'b1;
    end
  end

  // R2
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eop_valid && !init) |=> $stable(commit_q));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used_w) <= 32'(DEPTH));
  // R8
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (commit_q == rd_ptr));
endmodule

// File: rtl/rxq_reader.sv
`timescale 1ns/1ps
module rxq_reader import rxq_pkg::*; #(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              rd_en,
  input  logic [AW:0]       commit_ptr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [AW-1:0]     raddr,
  output logic [AW:0]       rd_ptr,
  output logic [WORD_W-1:0] rd_data,
  output logic              port_valid,
  output logic              avail
);
  logic [AW:0]       rd_ptr_q;
  logic [WORD_W-1:0] data_q;
  logic              valid_q;

  assign avail      = rd_ptr_q != commit_ptr;
  assign raddr      = rd_ptr_q[AW-1:0];
  assign rd_ptr     = rd_ptr_q;
  assign rd_data    = data_q;
  assign port_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      data_q   <= EMPTY_MARK;
      valid_q  <= 1'b0;
    end else if (init) begin
      rd_ptr_q <= '0;
      data_q   <= EMPTY_MARK;
      valid_q  <= 1'b0;
    end else if (rd_en) begin
      if (avail) begin
        data_q   <= mem_rdata;
        valid_q  <= 1'b1;
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end else begin
        data_q  <= EMPTY_MARK;
        valid_q <= 1'b0;
      end
    end
  end

  // R4
  empty_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || init)
    (rd_en && !avail) |=> (data_q == EMPTY_MARK && $stable(rd_ptr_q)));
  // R6
  lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n || init)
    (rd_en && !valid_q && avail) |=> !data_q[WORD_W-1]);
endmodule

// File: rtl/rx_pkt_queue.sv
`timescale 1ns/1ps
module rx_pkt_queue import rxq_pkg::*; #(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  input  logic        eop_valid,
  input  logic        eop_crc_err,
  input  logic        eop_coll,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        q_empty,
  output logic        rx_irq
);
  localparam int AW = $clog2(DEPTH);

  logic              mem_we;
  logic [AW-1:0]     mem_addr, raddr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic [AW:0]       commit_ptr, rd_ptr;
  logic              port_valid, avail;

  rxq_writer #(.DEPTH(DEPTH), .AW(AW)) u_writer (
    .clk(clk), .rst_n(rst_n), .init(init),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .eop_valid(eop_valid), .eop_crc_err(eop_crc_err), .eop_coll(eop_coll),
    .rd_ptr(rd_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .commit_ptr(commit_ptr)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW), .W(WORD_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(mem_rdata)
  );

  rxq_reader #(.AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_n), .init(init), .rd_en(rd_en),
    .commit_ptr(commit_ptr), .mem_rdata(mem_rdata), .raddr(raddr),
    .rd_ptr(rd_ptr), .rd_data(rd_data), .port_valid(port_valid), .avail(avail)
  );

  assign q_empty = !port_valid && !avail;
  assign rx_irq  = !q_empty;

  // input rule for R9: data word and end-of-packet never share a cycle
  wr_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && eop_valid));
endmodule

// File: tb/rx_pkt_queue_tb.sv
`timescale 1ns/1ps
module rx_pkt_queue_tb;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0, init = 1'b0, wr_valid = 1'b0, eop_valid = 1'b0;
  logic eop_crc_err = 1'b0, eop_coll = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic q_empty, rx_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_pkt_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .wr_valid(wr_valid), .wr_data(wr_data),
    .eop_valid(eop_valid), .eop_crc_err(eop_crc_err), .eop_coll(eop_coll),
    .rd_en(rd_en), .rd_data(rd_data), .q_empty(q_empty), .rx_irq(rx_irq)
  );

  // behavioural reference: committed words, pending packet, port word
  logic [15:0] mq[$];
  logic [15:0] pk[$];
  logic        m_ovf = 1'b0;
  logic [15:0] m_port = 16'h8000;
  logic        m_pv = 1'b0;

  always @(posedge clk) begin
    if (!rst_n || init) begin
      mq.delete(); pk.delete(); m_ovf = 1'b0; m_port = 16'h8000; m_pv = 1'b0;
    end else begin
      int room;
      room = DEPTH - mq.size();
      if (rd_en) begin
        if (mq.size() > 0) begin m_port = mq.pop_front(); m_pv = 1'b1; end
        else begin m_port = 16'h8000; m_pv = 1'b0; end
      end
      if (wr_valid) begin
        if (pk.size() + 2 <= room) pk.push_back(wr_data);
        else m_ovf = 1'b1;
      end
      if (eop_valid) begin
        if (pk.size() + 1 <= room) begin
          mq.push_back({1'b0, m_ovf, eop_coll, eop_crc_err, 12'(pk.size())});
          foreach (pk[i]) mq.push_back(pk[i]);
        end
        pk.delete(); m_ovf = 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic me;
      me = !m_pv && (mq.size() == 0);
      chk(rd_data == m_port, "R6 model rd_data", rd_data, m_port);
      chk(q_empty == me, "R3 model q_empty", 16'(q_empty), 16'(me));
      chk(rx_irq == !me, "R5 model rx_irq", 16'(rx_irq), 16'(!me));
    end
  end

  function automatic logic [15:0] pat(input int p, input int i);
    return 16'((p << 12) ^ i);
  endfunction

  task automatic push(input int p, input int n, input logic crc, input logic coll, input bit hidden);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = pat(p, i);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (hidden) chk(q_empty == 1'b1, "R2 partial packet hidden", 16'(q_empty), 16'h1);
    eop_valid = 1'b1; eop_crc_err = crc; eop_coll = coll;
    @(negedge clk);
    eop_valid = 1'b0; eop_crc_err = 1'b0; eop_coll = 1'b0;
  endtask

  task automatic rd_word(input logic [15:0] exp, input string tag);
    chk(rd_data == exp, tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_any();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h8000, "R4 reset marker", rd_data, 16'h8000);
    chk(q_empty == 1'b1, "R3 reset empty", 16'(q_empty), 16'h1);
    chk(rx_irq == 1'b0, "R5 reset irq", 16'(rx_irq), 16'h0);
    init = 1'b1; @(negedge clk); init = 1'b0;

    // single packet, CRC error
    push(1, 3, 1'b1, 1'b0, 1'b1);
    chk(q_empty == 1'b0, "R3 packet ready", 16'(q_empty), 16'h0);
    chk(rx_irq == 1'b1, "R5 irq raised", 16'(rx_irq), 16'h1);
    rd_word(16'h8000, "R6 lookahead invalid word");
    rd_word(16'h1003, "R1 header crc");
    for (int i = 0; i < 3; i++) rd_word(pat(1, i), "R6 data word");
    chk(q_empty == 1'b1, "R3 drained", 16'(q_empty), 16'h1);
    chk(rx_irq == 1'b0, "R5 irq cleared", 16'(rx_irq), 16'h0);
    for (int i = 0; i < 3; i++) rd_word(16'h8000, "R4 repeat empty read");

    // two queued packets
    push(2, 2, 1'b0, 1'b1, 1'b1);
    push(3, 1, 1'b0, 1'b0, 1'b0);
    rd_word(16'h8000, "R6 lookahead invalid word");
    rd_word(16'h2002, "R1 header collision");
    rd_word(pat(2, 0), "R6 data word");
    rd_word(pat(2, 1), "R6 data word");
    rd_word(16'h0001, "R6 back-to-back header");
    rd_word(pat(3, 0), "R6 data word");

    // reads overlapping writes
    push(4, 2, 1'b0, 1'b0, 1'b0);
    fork
      begin repeat (8) rd_any(); end
      push(5, 3, 1'b1, 1'b1, 1'b0);
    join
    while (!q_empty) rd_any();

    // overflow and full buffer
    push(6, 2100, 1'b0, 1'b0, 1'b0);
    rd_word(16'h8000, "R6 lookahead invalid word");
    rd_word(16'h47FF, "R7 truncated header");
    push(7, 5, 1'b1, 1'b0, 1'b0);
    rd_word(pat(6, 0), "R7 first stored word");
    repeat (2046) rd_any();
    rd_word(16'h5001, "R9 header in last slots");
    rd_word(pat(7, 0), "R9 last stored word");

    // flush
    push(8, 4, 1'b0, 1'b0, 1'b0);
    init = 1'b1; @(negedge clk); init = 1'b0;
    chk(q_empty == 1'b1, "R8 flushed empty", 16'(q_empty), 16'h1);
    chk(rd_data == 16'h8000, "R8 flushed marker", rd_data, 16'h8000);
    chk(rx_irq == 1'b0, "R8 flushed irq", 16'(rx_irq), 16'h0);
    push(9, 2, 1'b0, 1'b0, 1'b1);
    rd_word(16'h8000, "R8 lookahead after flush");
    rd_word(16'h0002, "R8 header after flush");
    repeat (4) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule